// File: doc/BRIEF.md
# Compressed-Stream Slice Parser

This block is the first parsing stage of a byte-oriented LZ77-style decompressor. Compressed input arrives as fixed windows of `WIN_BYTES` bytes (16 by default) over a valid/ready handshake. In a single cycle the block finds every token that begins inside the window. It reports how many there are, the byte position of each, and whether each one is a literal token (raw bytes follow) or a copy token (a back-reference into earlier output). The result is a slice record that later stages turn into memory commands.

Tokens do not line up with window edges. A long literal can cover many windows, and a token header can be cut in two by a window edge. The block keeps a carry state between windows so that it can handle both cases. For a token that began earlier, the state holds how many of its bytes are still to come and whether it is a literal. For a cut header, it holds the header bytes seen so far, and decoding of that header finishes in the next window. Every slice reports this leading-byte count and literal flag next to the token list.

Top module: `slice_parser`

## Requirements
- R1: A window is consumed only on a cycle with `in_valid_i` and `out_ready_i` both high. `out_valid_o` follows `in_valid_i` and `in_ready_o` follows `out_ready_i`. Byte 0 of a window, the first in stream order, is `in_data_i[7:0]`.
- R2: `tok_cnt_o` equals the number of tokens whose tag byte lies inside the current window.
- R3: Bit i of `tok_start_o` is set exactly when byte i of the window is a token tag byte.
- R4: Tag bits [1:0] give the token kind. 00 is a literal. 01, 10 and 11 are copies whose headers are 2, 3 and 5 bytes long. Bit i of `tok_copy_o` is set exactly when a copy token starts at byte i.
- R5: For a literal, tag bits [7:2] hold a value v. If v < 60, the header is 1 byte and the length is v+1. If v is 60 to 63, then v-59 length bytes follow the tag, least significant byte first, and the length is their value plus 1. The next token begins at the tag position plus the header size plus the literal length.
- R6: `carry_len_o` gives the number of bytes at the start of the window that belong to a token begun in an earlier window. None of those positions is marked as a start. If the value is 16 or more, the window has no starts at all.
- R7: When `carry_len_o` is nonzero, `carry_lit_o` is 1 if the earlier token is a literal and 0 if it is a copy.
- R8: When a header is cut by the window edge, its bytes are held and decoding finishes in the next window. That window's `carry_len_o` covers the rest of the header plus any literal payload.
- R9: While `out_ready_i` is low, no window is consumed and the carry state does not change. The slice shown for a held window stays the same from cycle to cycle.
- R10: After reset, the carry state is empty: `carry_len_o` is 0 and the first window's token begins at byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Input window valid |
| in_ready_o | output | 1 | Input window accepted when high with valid |
| in_data_i | input | 8*WIN_BYTES | Window bytes, byte 0 in bits [7:0] |
| out_valid_o | output | 1 | Slice record valid |
| out_ready_i | input | 1 | Downstream ready for the slice |
| tok_cnt_o | output | $clog2(WIN_BYTES+1) | Number of tokens starting in the window |
| tok_start_o | output | WIN_BYTES | Token start position mask |
| tok_copy_o | output | WIN_BYTES | Copy-token mask at start positions |
| carry_len_o | output | 34 | Leading bytes that belong to an earlier token |
| carry_lit_o | output | 1 | Earlier token is a literal |

## Verification
The bench uses the default 16-byte window. At that size a handful of hand-built windows can reach the important cases: a window full of copy tokens, headers cut at byte 15 or byte 14 for every header size, literals that use each of the four long-length encodings, and a literal long enough to cover fifteen whole windows with no token start. A stall is checked by offering a window that would change the carry state while `out_ready_i` is low, then confirming that the carry value seen afterwards has not moved.

// File: rtl/slice_pkg.sv
package slice_pkg;
  localparam int unsigned HDR_MAX = 5;
  localparam int unsigned LEN_W   = 34;

  typedef enum logic [1:0] {
    TAG_LIT = 2'b00,
    TAG_CP1 = 2'b01,
    TAG_CP2 = 2'b10,
    TAG_CP4 = 2'b11
  } tag_kind_e;

  typedef struct packed {
    logic             pend;
    logic             lit;
    logic [2:0]       have;
    logic [31:0]      held;
    logic [LEN_W-1:0] rem;
  } carry_t;

  function automatic logic [2:0] hdr_size(input logic [7:0] tag);
    logic [5:0] d;
    d = tag[7:2] - 6'd59;
    case (tag_kind_e'(tag[1:0]))
      TAG_LIT: hdr_size = (tag[7:2] >= 6'd60) ? 3'd1 + d[2:0] : 3'd1;
      TAG_CP1: hdr_size = 3'd2;
      TAG_CP2: hdr_size = 3'd3;
      default: hdr_size = 3'd5;
    endcase
  endfunction
endpackage

// File: rtl/slice_tok_decode.sv
module slice_tok_decode
  import slice_pkg::*;
(
  input  logic [8*HDR_MAX-1:0] hdr_i,
  output logic                 is_copy_o,
  output logic [2:0]           hsize_o,
  output logic [LEN_W-1:0]     pay_o
);
  logic [7:0]  tag;
  logic [5:0]  v;
  logic [5:0]  d;
  logic        long_len;
  logic [31:0] raw;
  logic [31:0] mask;

  assign tag      = hdr_i[7:0];
  assign v        = tag[7:2];
  assign d        = v - 6'd59;
  assign long_len = (v >= 6'd60);
  assign raw      = hdr_i[8*HDR_MAX-1:8];

  always_comb begin
    case (d[2:0])
      3'd1:    mask = 32'h0000_00ff;
      3'd2:    mask = 32'h0000_ffff;
      3'd3:    mask = 32'h00ff_ffff;
      default: mask = 32'hffff_ffff;
    endcase
  end

  assign is_copy_o = (tag_kind_e'(tag[1:0]) != TAG_LIT);
  assign hsize_o   = hdr_size(tag);

  always_comb begin
    if (is_copy_o)     pay_o = '0;
    else if (long_len) pay_o = LEN_W'(raw & mask) + LEN_W'(1);
    else               pay_o = LEN_W'(v) + LEN_W'(1);
  end
endmodule

// File: rtl/slice_hdr_merge.sv
module slice_hdr_merge
  import slice_pkg::*;
(
  input  logic [31:0]          held_i,
  input  logic [2:0]           have_i,
  input  logic [8*HDR_MAX-1:0] head_i,
  output logic [8*HDR_MAX-1:0] hdr_o
);
  for (genvar k = 0; k < HDR_MAX; k++) begin : g_byte
    logic [2:0] idx;
    assign idx = 3'(k) - have_i;
    if (k < 4) begin : g_held
      always_comb begin
        if (3'(k) < have_i) hdr_o[8*k +: 8] = held_i[8*k +: 8];
        else                hdr_o[8*k +: 8] = head_i[8*idx +: 8];
      end
    end else begin : g_head
      assign hdr_o[8*k +: 8] = head_i[8*idx +: 8];
    end
  end
endmodule

// File: rtl/slice_carry_reg.sv
module slice_carry_reg
  import slice_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   en_i,
  input  carry_t d_i,
  output carry_t q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (en_i) q_o <= d_i;
  end
endmodule

// File: rtl/slice_parser.sv
module slice_parser
  import slice_pkg::*;
#(
  parameter int unsigned WIN_BYTES = 16
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           in_valid_i,
  output logic                           in_ready_o,
  input  logic [8*WIN_BYTES-1:0]         in_data_i,
  output logic                           out_valid_o,
  input  logic                           out_ready_i,
  output logic [$clog2(WIN_BYTES+1)-1:0] tok_cnt_o,
  output logic [WIN_BYTES-1:0]           tok_start_o,
  output logic [WIN_BYTES-1:0]           tok_copy_o,
  output logic [LEN_W-1:0]               carry_len_o,
  output logic                           carry_lit_o
);
  localparam int unsigned POS_W = $clog2(WIN_BYTES);
  localparam int unsigned CNT_W = $clog2(WIN_BYTES+1);
  localparam int unsigned NXT_W = LEN_W + 1;
  localparam int unsigned PAD_W = 8*(WIN_BYTES+HDR_MAX-1);

  logic [PAD_W-1:0] padded;
  assign padded = {{(8*(HDR_MAX-1)){1'b0}}, in_data_i};

  logic             is_copy [WIN_BYTES];
  logic [2:0]       hsize   [WIN_BYTES];
  logic [LEN_W-1:0] pay     [WIN_BYTES];
  logic             fits    [WIN_BYTES];

  for (genvar g = 0; g < WIN_BYTES; g++) begin : g_pos
    slice_tok_decode u_dec (
      .hdr_i     (padded[8*g +: 8*HDR_MAX]),
      .is_copy_o (is_copy[g]),
      .hsize_o   (hsize[g]),
      .pay_o     (pay[g])
    );
    assign fits[g] = (32'(g) + 32'(hsize[g])) <= 32'(WIN_BYTES);
  end

  carry_t cur_q;
  carry_t nxt_d;
  logic   fire;

  assign fire        = in_valid_i & out_ready_i;
  assign in_ready_o  = out_ready_i;
  assign out_valid_o = in_valid_i;

  // completion of a header cut by the previous window edge
  logic [8*HDR_MAX-1:0] m_hdr;
  logic                 m_copy;
  logic [2:0]           m_hsize;
  logic [LEN_W-1:0]     m_pay;

  slice_hdr_merge u_merge (
    .held_i (cur_q.held),
    .have_i (cur_q.have),
    .head_i (padded[0 +: 8*HDR_MAX]),
    .hdr_o  (m_hdr)
  );

  slice_tok_decode u_mdec (
    .hdr_i     (m_hdr),
    .is_copy_o (m_copy),
    .hsize_o   (m_hsize),
    .pay_o     (m_pay)
  );

  always_comb begin
    if (cur_q.pend) begin
      carry_len_o = LEN_W'(m_hsize - cur_q.have) + m_pay;
      carry_lit_o = ~m_copy;
    end else begin
      carry_len_o = cur_q.rem;
      carry_lit_o = cur_q.lit;
    end
  end

  logic [NXT_W-1:0] nxt;
  logic [CNT_W-1:0] cnt;
  logic             split;
  logic [POS_W-1:0] split_pos;
  logic             any_start;
  logic             last_lit;

  always_comb begin
    nxt         = NXT_W'(carry_len_o);
    cnt         = '0;
    split       = 1'b0;
    split_pos   = '0;
    any_start   = 1'b0;
    last_lit    = carry_lit_o;
    tok_start_o = '0;
    tok_copy_o  = '0;
    for (int i = 0; i < WIN_BYTES; i++) begin
      if (nxt == NXT_W'(i)) begin
        tok_start_o[i] = 1'b1;
        tok_copy_o[i]  = is_copy[i];
        cnt            = cnt + CNT_W'(1);
        any_start      = 1'b1;
        last_lit       = ~is_copy[i];
        if (fits[i]) begin
          nxt = NXT_W'(i) + NXT_W'(hsize[i]) + NXT_W'(pay[i]);
        end else begin
          split     = 1'b1;
          split_pos = POS_W'(i);
          nxt       = '1;
        end
      end
    end
    tok_cnt_o = cnt;
  end

  always_comb begin
    nxt_d      = '0;
    nxt_d.lit  = any_start ? last_lit : carry_lit_o;
    if (split) begin
      nxt_d.pend = 1'b1;
      nxt_d.have = 3'(WIN_BYTES - 32'(split_pos));
      nxt_d.held = padded[8*split_pos +: 32];
    end else begin
      nxt_d.rem  = LEN_W'(nxt - NXT_W'(WIN_BYTES));
    end
  end

  slice_carry_reg u_carry (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (fire),
    .d_i    (nxt_d),
    .q_o    (cur_q)
  );
endmodule

// File: rtl/slice_parser_chk.sv
module slice_parser_chk
  import slice_pkg::*;
#(
  parameter int unsigned WIN_BYTES = 16
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic                           in_valid_i,
  input logic                           out_ready_i,
  input logic                           out_valid_o,
  input logic [$clog2(WIN_BYTES+1)-1:0] tok_cnt_o,
  input logic [WIN_BYTES-1:0]           tok_start_o,
  input logic [WIN_BYTES-1:0]           tok_copy_o,
  input logic [LEN_W-1:0]               carry_len_o,
  input logic                           pend_i,
  input logic [LEN_W-1:0]               rem_i
);
  localparam int unsigned POS_W = $clog2(WIN_BYTES);

  logic [WIN_BYTES-1:0] lead_mask;
  always_comb begin
    for (int i = 0; i < WIN_BYTES; i++) lead_mask[i] = (LEN_W'(i) < carry_len_o);
  end

  AST_CNT_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (32'(tok_cnt_o) == $countones(tok_start_o))); // R2
  AST_FIRST_TOKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && carry_len_o < LEN_W'(WIN_BYTES)) |-> tok_start_o[carry_len_o[POS_W-1:0]]); // R3
  AST_COPY_AT_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> ((tok_copy_o & ~tok_start_o) == '0)); // R4
  AST_LEAD_NO_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> ((tok_start_o & lead_mask) == '0)); // R6
  AST_PEND_LEAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_i |-> (carry_len_o != '0)); // R8
  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && !out_ready_i) |=> ($stable(pend_i) && $stable(rem_i))); // R9
endmodule

bind slice_parser slice_parser_chk #(.WIN_BYTES(WIN_BYTES)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .out_ready_i (out_ready_i),
  .out_valid_o (out_valid_o),
  .tok_cnt_o   (tok_cnt_o),
  .tok_start_o (tok_start_o),
  .tok_copy_o  (tok_copy_o),
  .carry_len_o (carry_len_o),
  .pend_i      (cur_q.pend),
  .rem_i       (cur_q.rem)
);

// File: tb/slice_parser_bench.sv
module slice_parser_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          in_valid_i = 1'b0;
  logic          in_ready_o;
  logic [8*W-1:0] in_data_i = '0;
  logic          out_valid_o;
  logic          out_ready_i = 1'b0;
  logic [4:0]    tok_cnt_o;
  logic [W-1:0]  tok_start_o;
  logic [W-1:0]  tok_copy_o;
  logic [33:0]   carry_len_o;
  logic          carry_lit_o;

  int n_run = 0;
  int n_fail = 0;
  logic [7:0] w [W];

  slice_parser #(.WIN_BYTES(W)) u_slice_parser (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic chk(input string req, input longint act, input longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clr();
    for (int i = 0; i < W; i++) w[i] = 8'hee;
  endtask

  task automatic drive(input logic rdy);
    @(negedge clk_i);
    for (int i = 0; i < W; i++) in_data_i[8*i +: 8] = w[i];
    in_valid_i  = 1'b1;
    out_ready_i = rdy;
    #1;
  endtask

  // elit < 0 skips the literal flag check
  task automatic present(input string tn, input int ecnt, input int estart,
                         input int ecopy, input longint erem, input int elit);
    drive(1'b1);
    chk({"R2 ", tn}, longint'(tok_cnt_o), ecnt);
    chk({"R3 ", tn}, longint'(tok_start_o), estart);
    chk({"R4 ", tn}, longint'(tok_copy_o), ecopy);
    chk({"R6 ", tn}, longint'(carry_len_o), erem);
    if (elit >= 0) chk({"R7 ", tn}, longint'(carry_lit_o), elit);
    @(posedge clk_i);
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    chk("R1 no valid out when idle", longint'(out_valid_o), 0);
    chk("R1 ready follows downstream", longint'(in_ready_o), 0);
    chk("R10 empty carry after reset", longint'(carry_len_o), 0);
  endtask

  task automatic t_copy_run();
    clr();
    for (int i = 0; i < W; i += 2) w[i] = 8'h01;
    present("R10 copy run from byte 0", 8, 16'h5555, 16'h5555, 0, -1);
  endtask

  task automatic t_literal_mix();
    clr();
    w[0] = 8'h08; w[4] = 8'h02; w[7] = 8'h4c;
    present("R5 short literals", 3, 16'h0091, 16'h0010, 0, -1);
    clr();
    w[12] = 8'h02; w[15] = 8'h00;
    present("R5 tail of literal", 2, 16'h9000, 16'h1000, 12, 1);
    clr();
    for (int i = 1; i < W; i += 2) w[i] = 8'h01;
    present("R8 copy header cut at 15", 8, 16'haaaa, 16'haaaa, 1, 1);
  endtask

  task automatic t_long_literal();
    clr();
    w[0] = 8'hab; w[1] = 8'hf4; w[2] = 8'h00; w[3] = 8'h01;
    present("R8 copy1 completes, R5 2-byte length", 1, 16'h0002, 0, 1, 0);
    for (int k = 0; k < 15; k++) begin
      clr();
      w[0] = 8'h01; w[5] = 8'h02;
      present("R6 literal covers window", 0, 0, 0, 245 - 16*k, 1);
    end
    clr();
    w[5] = 8'hf0; w[6] = 8'h07; w[15] = 8'h03;
    present("R5 1-byte length after long run", 2, 16'h8020, 16'h8000, 5, 1);
  endtask

  task automatic t_split_headers();
    clr();
    w[4] = 8'hf8; w[5] = 8'h02; w[6] = 8'h00; w[7] = 8'h00;
    w[11] = 8'hfc; w[12] = 8'h09; w[13] = 8'h00; w[14] = 8'h00; w[15] = 8'h00;
    present("R8 copy4 header completes, R5 4-byte length", 2, 16'h0810, 0, 4, 0);
    clr();
    w[10] = 8'h08; w[14] = 8'hf8; w[15] = 8'h02;
    present("R8 literal header cut at 14", 2, 16'h4400, 0, 10, 1);
    clr();
    w[0] = 8'h00; w[1] = 8'h00;
    for (int i = 5; i < 15; i += 2) w[i] = 8'h01;
    w[15] = 8'h02;
    present("R8 literal header completes", 6, 16'haaa0, 16'haaa0, 5, 1);
    clr();
    w[2] = 8'h3c;
    present("R8 copy2 header completes", 1, 16'h0004, 0, 2, 0);
  endtask

  task automatic t_stall();
    for (int i = 0; i < W; i++) w[i] = 8'h00;
    drive(1'b0);
    chk("R9 ready low under stall", longint'(in_ready_o), 0);
    chk("R1 valid passes through", longint'(out_valid_o), 1);
    chk("R9 held slice count", longint'(tok_cnt_o), 7);
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    #1;
    chk("R9 held slice count stable", longint'(tok_cnt_o), 7);
    chk("R9 carry unchanged under stall", longint'(carry_len_o), 3);
    in_valid_i  = 1'b0;
    out_ready_i = 1'b1;
    #1;
    chk("R1 valid drops with input", longint'(out_valid_o), 0);
    @(posedge clk_i);
    clr();
    for (int i = 3; i < 15; i += 2) w[i] = 8'h01;
    w[15] = 8'h00;
    present("R9 window after stall", 7, 16'haaa8, 16'h2aa8, 3, 1);
    @(negedge clk_i);
    in_valid_i = 1'b0;
    #1;
    chk("R1 idle carries last remainder", longint'(carry_len_o), 1);
  endtask

  initial begin
    t_reset();
    t_copy_run();
    t_literal_mix();
    t_long_literal();
    t_split_headers();
    t_stall();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*50000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule